// File: doc/BRIEF.md
# Scalar FP64 Mantissa Extraction Unit

This block takes one double-precision operand and returns its significand rescaled into one of four intervals, with the sign of the result chosen by a sign policy. The result exponent is either 0 or -1. It is picked from the interval code and, depending on that code, from the parity of the source exponent or the top fraction bit. The fraction field of a normal source passes through unchanged. Subnormal sources are normalized first. NaN, zero and infinity inputs have their own rules. One sign policy rejects negative numbers by returning the default quiet NaN and raising invalid.

The computed value goes into the low 64 bits of a 128-bit result under a one-bit write mask. The mask can be merging or zeroing. The upper 64 bits always come from the first source. All outputs are registered: the result and the two exception flags, denormal and invalid, appear one clock edge after the inputs are presented. There is no handshake.

Top module: `fp64_mant_unit`

## Requirements
- R1: A synchronous active-high reset clears the 128-bit result and both flags to zero.
- R2: The result and flags change only on a rising clock edge, and they reflect the inputs sampled at that edge.
- R3: The exponent field of a finite non-zero result is 0x3FF (k=0) or 0x3FE (k=-1). The interval code is imm[1:0]. Code 00 always gives k=0. Code 01 gives k=-1 when the unbiased source exponent is odd and k=0 when it is even. Code 10 always gives k=-1. Code 11 gives k=-1 when the top fraction bit (bit 51) is 1 and k=0 otherwise. For a normal source, the result fraction bits [51:0] equal the source's.
- R4: The sign policy is imm[3:2]. Code 00 keeps the source sign (bit 63). Code 01 gives a positive result. Code 1x gives a positive result for every non-negative source and for negative zero. Bits imm[7:4] have no effect.
- R5: Under sign policy 1x, a negative non-zero finite source or negative infinity gives 0xFFF8000000000000 and raises invalid.
- R6: A subnormal source (exponent field 0, fraction non-zero) raises the denormal flag. It is shifted left until its leading one becomes the hidden bit, and the adjusted exponent supplies the parity used by interval 01.
- R7: A NaN source returns the same value with fraction bit 51 set. Invalid is raised only when bit 51 was clear on input (a signalling NaN).
- R8: A zero or infinite source returns magnitude 1.0 (0x3FF0000000000000), with the sign given by the sign policy.
- R9: When the mask is off (mask_en_i=0) or the mask bit is 1, the low 64 bits take the computed value. Otherwise they take dst_old_i in merging mode (zero_mode_i=0) or zero in zeroing mode, and neither flag is raised.
- R10: Result bits [127:64] always equal src1_i[127:64], whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src1_i | input | 128 | First source; its upper half is copied to the result |
| src2_i | input | 64 | FP64 operand |
| dst_old_i | input | 64 | Prior low destination value used by merging |
| imm_i | input | 8 | [1:0] interval code, [3:2] sign policy |
| mask_bit_i | input | 1 | Write-mask bit for the low element |
| mask_en_i | input | 1 | A write mask is in use |
| zero_mode_i | input | 1 | 1 = zeroing, 0 = merging when masked off |
| res_o | output | 128 | Registered result |
| flag_denorm_o | output | 1 | Registered denormal exception flag |
| flag_invalid_o | output | 1 | Registered invalid exception flag |

## Verification
On every cycle the assertions check the following: the upper-half copy, merging and zeroing of masked-off elements, silence of the flags when masked off, the exponent field staying in {0x3FE, 0x3FF} for ordinary inputs, pass-through of a normal fraction, the denormal flag for subnormals, and the reset clear. Only the directed scenarios show which of the two exponents each interval code picks. The same holds for parity recovered from a normalized subnormal, NaN quieting, the special returns for zero and infinity, the negative-input NaN and the fact that the upper immediate bits have no effect.

// File: rtl/fp64_mant_unit.sv
module fp64_mant_unit (
  input  logic         clk,
  input  logic         rst,
  input  logic [127:0] src1_i,
  input  logic [63:0]  src2_i,
  input  logic [63:0]  dst_old_i,
  input  logic [7:0]   imm_i,
  input  logic         mask_bit_i,
  input  logic         mask_en_i,
  input  logic         zero_mode_i,
  output logic [127:0] res_o,
  output logic         flag_denorm_o,
  output logic         flag_invalid_o
);

  localparam logic [63:0] DEF_QNAN = 64'hFFF8_0000_0000_0000;
  localparam logic [10:0] EXP_K0   = 11'h3FF;
  localparam logic [10:0] EXP_KM1  = 11'h3FE;

  function automatic logic [5:0] lead_zeros(input logic [51:0] v);
    logic [5:0] n;
    logic       hit;
    n   = 6'd52;
    hit = 1'b0;
    for (int i = 51; i >= 0; i--) begin
      if (!hit && v[i]) begin
        n   = 6'(51 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  logic        sgn;
  logic [10:0] exf;
  logic [51:0] frc;
  logic [1:0]  intv;
  logic [1:0]  sctl;

  assign sgn  = src2_i[63];
  assign exf  = src2_i[62:52];
  assign frc  = src2_i[51:0];
  assign intv = imm_i[1:0];
  assign sctl = imm_i[3:2];

  logic unused_bits;
  assign unused_bits = ^{src1_i[63:0], imm_i[7:4]};

  logic exp_zero, exp_max, frc_nz;
  logic is_nan, is_inf, is_zero, is_sub;

  assign exp_zero = (exf == 11'd0);
  assign exp_max  = (exf == 11'h7FF);
  assign frc_nz   = |frc;
  assign is_nan   = exp_max & frc_nz;
  assign is_inf   = exp_max & ~frc_nz;
  assign is_zero  = exp_zero & ~frc_nz;
  assign is_sub   = exp_zero & frc_nz;

  logic [5:0]  lz;
  logic [52:0] shifted;
  logic [51:0] nfrc;
  logic        odd_exp;

  assign lz      = lead_zeros(frc);
  assign shifted = {1'b0, frc} << (lz + 6'd1);
  assign nfrc    = is_sub ? shifted[51:0] : frc;
  assign odd_exp = is_sub ? ~lz[0] : ~exf[0];

  logic k_neg;
  always_comb begin
    case (intv)
      2'b00:   k_neg = 1'b0;
      2'b01:   k_neg = odd_exp;
      2'b10:   k_neg = 1'b1;
      default: k_neg = nfrc[51];
    endcase
  end

  logic neg_reject, out_sgn;
  assign neg_reject = sctl[1] & sgn & ~is_nan & ~is_zero;
  assign out_sgn    = (sctl == 2'b00) ? sgn : 1'b0;

  logic [63:0] calc;
  logic        calc_inv;
  always_comb begin
    calc_inv = 1'b0;
    if (is_nan) begin
      calc     = {sgn, exf, 1'b1, frc[50:0]};
      calc_inv = ~frc[51];
    end else if (neg_reject) begin
      calc     = DEF_QNAN;
      calc_inv = 1'b1;
    end else if (is_zero || is_inf) begin
      calc = {out_sgn, EXP_K0, 52'd0};
    end else begin
      calc = {out_sgn, k_neg ? EXP_KM1 : EXP_K0, nfrc};
    end
  end

  logic        take;
  logic [63:0] low_next;
  assign take     = mask_bit_i | ~mask_en_i;
  assign low_next = take ? calc : (zero_mode_i ? 64'd0 : dst_old_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o          <= '0;
      flag_denorm_o  <= 1'b0;
      flag_invalid_o <= 1'b0;
    end else begin
      res_o          <= {src1_i[127:64], low_next};
      flag_denorm_o  <= take & is_sub;
      flag_invalid_o <= take & calc_inv;
    end
  end

endmodule

module fp64_mant_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic [127:0] src1_i,
  input logic [63:0]  src2_i,
  input logic [63:0]  dst_old_i,
  input logic [7:0]   imm_i,
  input logic         mask_bit_i,
  input logic         mask_en_i,
  input logic         zero_mode_i,
  input logic [127:0] res_o,
  input logic         flag_denorm_o,
  input logic         flag_invalid_o
);

  logic act;
  logic in_normal;
  assign act       = mask_bit_i | ~mask_en_i;
  assign in_normal = (src2_i[62:52] != 11'd0) && (src2_i[62:52] != 11'h7FF);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_o == '0) && !flag_denorm_o && !flag_invalid_o);

  a_r10_upper_copy: assert property (@(posedge clk) disable iff (rst)
    !rst |=> res_o[127:64] == $past(src1_i[127:64]));

  a_r9_zero_mask: assert property (@(posedge clk) disable iff (rst)
    (!rst && !act && zero_mode_i) |=> res_o[63:0] == 64'd0);

  a_r9_merge: assert property (@(posedge clk) disable iff (rst)
    (!rst && !act && !zero_mode_i) |=> res_o[63:0] == $past(dst_old_i));

  a_r9_flags_quiet: assert property (@(posedge clk) disable iff (rst)
    (!rst && !act) |=> !flag_denorm_o && !flag_invalid_o);

  a_r3_exp_range: assert property (@(posedge clk) disable iff (rst)
    (!rst && act && src2_i[62:52] != 11'h7FF && !imm_i[3])
      |=> (res_o[62:52] == 11'h3FE || res_o[62:52] == 11'h3FF) && !flag_invalid_o);

  a_r3_frac_pass: assert property (@(posedge clk) disable iff (rst)
    (!rst && act && in_normal && !(imm_i[3] && src2_i[63]))
      |=> res_o[51:0] == $past(src2_i[51:0]));

  a_r6_denorm_flag: assert property (@(posedge clk) disable iff (rst)
    (!rst && act && src2_i[62:52] == 11'd0 && src2_i[51:0] != 52'd0) |=> flag_denorm_o);

endmodule

bind fp64_mant_unit fp64_mant_unit_chk u_chk (.*);

// File: tb/tb_fp64_mant_unit.sv
module tb_fp64_mant_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src1_i = '0;
  logic [63:0]  src2_i = '0;
  logic [63:0]  dst_old_i = '0;
  logic [7:0]   imm_i = '0;
  logic         mask_bit_i = 1'b0;
  logic         mask_en_i = 1'b0;
  logic         zero_mode_i = 1'b0;
  logic [127:0] res_o;
  logic         flag_denorm_o;
  logic         flag_invalid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fp64_mant_unit dut (.*);

  localparam logic [63:0] UPPER = 64'hA5A5_1234_5678_9ABC;

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [63:0] v, input logic [7:0] imm,
                       input logic me, input logic mb, input logic zm, input logic [63:0] old);
    @(negedge clk);
    src1_i      = {UPPER, 64'h1111_2222_3333_4444};
    src2_i      = v;
    imm_i       = imm;
    mask_en_i   = me;
    mask_bit_i  = mb;
    zero_mode_i = zm;
    dst_old_i   = old;
    @(posedge clk);
    #1;
  endtask

  task automatic run(input string req, input logic [63:0] v, input logic [7:0] imm,
                     input logic [63:0] exp, input logic den, input logic inv);
    drive(v, imm, 1'b0, 1'b0, 1'b0, 64'h0);
    check(req, {64'h0, res_o[63:0]}, {64'h0, exp});
    check({req, " flags"}, {126'h0, flag_denorm_o, flag_invalid_o}, {126'h0, den, inv});
    check("R10", {64'h0, res_o[127:64]}, {64'h0, UPPER});
  endtask

  task automatic t_reset();
    check("R1", res_o, '0);
    check("R1 flags", {126'h0, flag_denorm_o, flag_invalid_o}, '0);
  endtask

  task automatic t_latency();
    drive(64'h4008_0000_0000_0000, 8'h00, 1'b0, 1'b0, 1'b0, 64'h0);
    @(negedge clk);
    src2_i = 64'h4014_0000_0000_0000;
    #1;
    check("R2 held before edge", {64'h0, res_o[63:0]}, {64'h0, 64'h3FF8_0000_0000_0000});
    @(posedge clk);
    #1;
    check("R2 after edge", {64'h0, res_o[63:0]}, {64'h0, 64'h3FF4_0000_0000_0000});
  endtask

  task automatic t_intervals();
    run("R3 3.0 i00", 64'h4008_0000_0000_0000, 8'h00, 64'h3FF8_0000_0000_0000, 0, 0);
    run("R3 3.0 i01 odd", 64'h4008_0000_0000_0000, 8'h01, 64'h3FE8_0000_0000_0000, 0, 0);
    run("R3 3.0 i10", 64'h4008_0000_0000_0000, 8'h02, 64'h3FE8_0000_0000_0000, 0, 0);
    run("R3 3.0 i11 msb1", 64'h4008_0000_0000_0000, 8'h03, 64'h3FE8_0000_0000_0000, 0, 0);
    run("R3 5.0 i01 even", 64'h4014_0000_0000_0000, 8'h01, 64'h3FF4_0000_0000_0000, 0, 0);
    run("R3 5.0 i11 msb0", 64'h4014_0000_0000_0000, 8'h03, 64'h3FF4_0000_0000_0000, 0, 0);
    run("R3 5.0 i10", 64'h4014_0000_0000_0000, 8'h02, 64'h3FE4_0000_0000_0000, 0, 0);
  endtask

  task automatic t_sign();
    run("R4 -3 keep", 64'hC008_0000_0000_0000, 8'h00, 64'hBFF8_0000_0000_0000, 0, 0);
    run("R4 -3 force pos", 64'hC008_0000_0000_0000, 8'h04, 64'h3FF8_0000_0000_0000, 0, 0);
    run("R4 upper imm ignored", 64'hC008_0000_0000_0000, 8'hF0, 64'hBFF8_0000_0000_0000, 0, 0);
    run("R4 +3 sc10", 64'h4008_0000_0000_0000, 8'h08, 64'h3FF8_0000_0000_0000, 0, 0);
    run("R5 -3 sc10", 64'hC008_0000_0000_0000, 8'h08, 64'hFFF8_0000_0000_0000, 0, 1);
    run("R5 -3 sc11", 64'hC008_0000_0000_0000, 8'h0D, 64'hFFF8_0000_0000_0000, 0, 1);
    run("R5 -inf sc10", 64'hFFF0_0000_0000_0000, 8'h08, 64'hFFF8_0000_0000_0000, 0, 1);
  endtask

  task automatic t_subnormal();
    run("R6 min sub i01", 64'h0000_0000_0000_0001, 8'h01, 64'h3FF0_0000_0000_0000, 1, 0);
    run("R6 top sub i01", 64'h0008_0000_0000_0000, 8'h01, 64'h3FE0_0000_0000_0000, 1, 0);
    run("R6 sub i11", 64'h000C_0000_0000_0000, 8'h03, 64'h3FE8_0000_0000_0000, 1, 0);
    run("R6 sub i00", 64'h000C_0000_0000_0000, 8'h00, 64'h3FF8_0000_0000_0000, 1, 0);
    run("R6 neg sub sc10", 64'h8000_0000_0000_0001, 8'h08, 64'hFFF8_0000_0000_0000, 1, 1);
  endtask

  task automatic t_specials();
    run("R7 snan", 64'h7FF0_0000_0000_0001, 8'h00, 64'h7FF8_0000_0000_0001, 0, 1);
    run("R7 qnan", 64'hFFF8_0000_0000_0123, 8'h05, 64'hFFF8_0000_0000_0123, 0, 0);
    run("R8 +0", 64'h0000_0000_0000_0000, 8'h02, 64'h3FF0_0000_0000_0000, 0, 0);
    run("R8 -0 keep", 64'h8000_0000_0000_0000, 8'h00, 64'hBFF0_0000_0000_0000, 0, 0);
    run("R8 -0 sc10", 64'h8000_0000_0000_0000, 8'h08, 64'h3FF0_0000_0000_0000, 0, 0);
    run("R8 -inf keep", 64'hFFF0_0000_0000_0000, 8'h00, 64'hBFF0_0000_0000_0000, 0, 0);
    run("R8 +inf sc01", 64'h7FF0_0000_0000_0000, 8'h06, 64'h3FF0_0000_0000_0000, 0, 0);
  endtask

  task automatic t_mask();
    drive(64'h7FF0_0000_0000_0001, 8'h00, 1'b1, 1'b0, 1'b0, 64'hDEAD_BEEF_0000_0042);
    check("R9 merge", {64'h0, res_o[63:0]}, {64'h0, 64'hDEAD_BEEF_0000_0042});
    check("R9 merge flags", {126'h0, flag_denorm_o, flag_invalid_o}, '0);
    check("R10 masked", {64'h0, res_o[127:64]}, {64'h0, UPPER});
    drive(64'h0000_0000_0000_0001, 8'h00, 1'b1, 1'b0, 1'b1, 64'hDEAD_BEEF_0000_0042);
    check("R9 zeroing", {64'h0, res_o[63:0]}, '0);
    check("R9 zeroing flags", {126'h0, flag_denorm_o, flag_invalid_o}, '0);
    drive(64'h4008_0000_0000_0000, 8'h00, 1'b1, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0042);
    check("R9 bit set", {64'h0, res_o[63:0]}, {64'h0, 64'h3FF8_0000_0000_0000});
    drive(64'h4008_0000_0000_0000, 8'h00, 1'b0, 1'b0, 1'b1, 64'hDEAD_BEEF_0000_0042);
    check("R9 no mask", {64'h0, res_o[63:0]}, {64'h0, 64'h3FF8_0000_0000_0000});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_latency();
    t_intervals();
    t_sign();
    t_subnormal();
    t_specials();
    t_mask();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule